// File: doc/BRIEF.md
# Banked Lane Scratchpad with Conflict Serialization

This block is a 16 KB on-chip scratchpad that one group of 16 parallel lanes shares. Its storage is a set of 16 word-interleaved banks, each 32 bits wide. A request arrives through a valid/ready handshake. It carries one byte address per lane, an active-lane mask, a single read/write flag for the whole request, and write data per lane.

The block looks for bank collisions among the active lanes. It then issues the request as the smallest number of passes in which no bank is asked for two different words. Within one pass, lanes that ask for the same word share that bank access. Readers of a word all receive the same data. Among writers of a word, the highest-numbered lane's data is the one stored.

When the last pass completes, the block emits a one-cycle done pulse. The pulse carries the number of passes used and the read data for every lane. The block accepts no new request while passes are still outstanding.

Top module: `lane_scratchpad`

## Requirements
- R1: A lane's bank is byte-address bits [5:2] and its row inside the bank is bits [13:6]. Bits [1:0] are ignored, so any byte address inside a word reaches that same 32-bit word.
- R2: A word written by a write request is returned unchanged by any later read request for that word, at every address from 0 to 16383.
- R3: The pass count reported on done equals the largest number of distinct words that the active lanes request in any single bank. It is 1 when no lane is active, and it always lies between 1 and 16.
- R4: Active read lanes that ask for the same word all receive that word's data, and this adds no pass.
- R5: When several active lanes write one word in a single request, the stored value is the data of the highest-numbered of those lanes, and this adds no pass.
- R6: Inactive lanes add no pass and return zero read data. A write request returns zero read data on every lane.
- R7: req_ready is high when the block is idle and low from the cycle after an accepted request until done. done_valid is high for exactly one cycle, and req_ready is high again in that same cycle.
- R8: done_valid is visible after P+1 rising edges that follow the accepting edge, where P is the reported pass count.
- R9: After reset, req_ready is 1, done_valid is 0, done_passes is 0 and all read data is 0.
- R10: The write data of inactive lanes is never stored; the words those lanes point at keep their previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_mask | input | 16 | Active-lane mask, bit n is lane n |
| req_addr | input | 224 | Lane byte addresses, lane n at bits [14n+13:14n] |
| req_wdata | input | 512 | Lane write data, lane n at bits [32n+31:32n] |
| done_valid | output | 1 | One-cycle completion pulse |
| done_passes | output | 5 | Number of passes used by the completed request |
| done_rdata | output | 512 | Lane read data, lane n at bits [32n+31:32n] |

## Verification
The assertions assume that reset is held from time zero through at least one rising edge, and that the request fields carry known values whenever req_valid and req_ready are both high. They assume nothing about req_valid while the block is busy, because the block latches a request only at acceptance. The bench holds reset from time zero for several cycles. It drives every address, mask and data bit on each request and raises req_valid only in a cycle where it has seen req_ready high, so every property sees well-formed traffic.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

  typedef enum logic [1:0] {
    LSP_IDLE = 2'd0,
    LSP_RUN  = 2'd1,
    LSP_FIN  = 2'd2
  } lsp_state_e;

endpackage

// File: rtl/lsp_bank_ram.sv
// One bank: single port, synchronous read, written so block RAM can be inferred.
module lsp_bank_ram #(
  parameter int ROWS   = 256,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[row] <= wdata;
      end
      rdata <= mem[row];
    end
  end

endmodule

// File: rtl/lsp_pass_picker.sv
// Combinational pass selection: per bank, the lowest pending lane picks the row;
// every pending lane on that same word is served in this pass.
module lsp_pass_picker #(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int ROW_W  = 8,
  parameter int DATA_W = 32,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic [LANES-1:0]  pending,
  input  logic [BANK_W-1:0] lane_bank  [LANES],
  input  logic [ROW_W-1:0]  lane_row   [LANES],
  input  logic [DATA_W-1:0] lane_wdata [LANES],
  output logic [LANES-1:0]  served,
  output logic [BANKS-1:0]  bank_en,
  output logic [ROW_W-1:0]  bank_row   [BANKS],
  output logic [DATA_W-1:0] bank_wdata [BANKS]
);

  // Leader per bank: scanning downwards leaves the lowest pending lane.
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bank_en[b]  = 1'b0;
      bank_row[b] = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pending[l] && (lane_bank[l] == BANK_W'(b))) begin
          bank_en[b]  = 1'b1;
          bank_row[b] = lane_row[l];
        end
      end
    end
  end

  // A pending lane rides along when its row matches its bank's leader row.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      served[l] = pending[l] && (lane_row[l] == bank_row[lane_bank[l]]);
    end
  end

  // Write merge: scanning upwards leaves the highest served lane's data.
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bank_wdata[b] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (served[l] && (lane_bank[l] == BANK_W'(b))) begin
          bank_wdata[b] = lane_wdata[l];
        end
      end
    end
  end

endmodule

// File: rtl/lsp_read_gather.sv
// Per-lane read capture: a lane loads its bank's output one cycle after it was served.
module lsp_read_gather #(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int DATA_W = 32,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [LANES-1:0]  cap,
  input  logic [BANK_W-1:0] lane_bank  [LANES],
  input  logic [DATA_W-1:0] bank_rdata [BANKS],
  output logic [DATA_W-1:0] lane_rdata [LANES]
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        lane_rdata[l] <= '0;
      end else if (cap[l]) begin
        lane_rdata[l] <= bank_rdata[lane_bank[l]];
      end
    end
  end

endmodule

// File: rtl/lane_scratchpad.sv
module lane_scratchpad #(
  parameter int LANES     = 16,
  parameter int BANKS     = 16,
  parameter int DATA_W    = 32,
  parameter int CAP_BYTES = 16384,
  localparam int ADDR_W   = $clog2(CAP_BYTES),
  localparam int PCNT_W   = $clog2(LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [LANES-1:0]          req_mask,
  input  logic [LANES*ADDR_W-1:0]   req_addr,
  input  logic [LANES*DATA_W-1:0]   req_wdata,
  output logic                      done_valid,
  output logic [PCNT_W-1:0]         done_passes,
  output logic [LANES*DATA_W-1:0]   done_rdata
);
  import lsp_pkg::*;

  localparam int BYTES_W = DATA_W / 8;
  localparam int WOFF    = $clog2(BYTES_W);
  localparam int BANK_W  = $clog2(BANKS);
  localparam int ROWS    = CAP_BYTES / BYTES_W / BANKS;
  localparam int ROW_W   = $clog2(ROWS);
  localparam int WADDR_W = BANK_W + ROW_W;

  lsp_state_e state_q;
  logic       wr_q;
  logic [LANES-1:0]   pending_q;
  logic [LANES-1:0]   cap_q;
  logic [PCNT_W-1:0]  passes_q;
  logic               done_q;
  logic [PCNT_W-1:0]  done_passes_q;
  logic [WADDR_W-1:0] waddr_q  [LANES];
  logic [DATA_W-1:0]  wdata_q  [LANES];

  logic [BANK_W-1:0]  lane_bank  [LANES];
  logic [ROW_W-1:0]   lane_row   [LANES];
  logic [DATA_W-1:0]  gath_rdata [LANES];
  logic [LANES-1:0]   served;
  logic [LANES-1:0]   remain;
  logic [BANKS-1:0]   bank_en;
  logic [ROW_W-1:0]   bank_row   [BANKS];
  logic [DATA_W-1:0]  bank_wdata [BANKS];
  logic [DATA_W-1:0]  bank_rdata [BANKS];
  logic               accept;
  logic               running;
  logic [LANES*WOFF-1:0] unused_low_bits;

  assign req_ready = (state_q == LSP_IDLE);
  assign accept    = req_valid && req_ready;
  assign running   = (state_q == LSP_RUN);
  assign remain    = pending_q & ~served;

  // Per-lane address split and output packing.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bank[l] = waddr_q[l][BANK_W-1:0];
    assign lane_row[l]  = waddr_q[l][WADDR_W-1:BANK_W];
    assign done_rdata[l*DATA_W +: DATA_W] = gath_rdata[l];
    assign unused_low_bits[l*WOFF +: WOFF] = req_addr[l*ADDR_W +: WOFF];

    always_ff @(posedge clk) begin
      if (accept) begin
        waddr_q[l] <= req_addr[l*ADDR_W + WOFF +: WADDR_W];
        wdata_q[l] <= req_wdata[l*DATA_W +: DATA_W];
      end
    end
  end

  // Pass sequencing.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= LSP_IDLE;
      wr_q          <= 1'b0;
      pending_q     <= '0;
      cap_q         <= '0;
      passes_q      <= '0;
      done_q        <= 1'b0;
      done_passes_q <= '0;
    end else begin
      done_q <= 1'b0;
      cap_q  <= '0;
      case (state_q)
        LSP_IDLE: begin
          if (accept) begin
            wr_q      <= req_write;
            pending_q <= req_mask;
            passes_q  <= '0;
            state_q   <= LSP_RUN;
          end
        end
        LSP_RUN: begin
          pending_q <= remain;
          passes_q  <= passes_q + 1'b1;
          cap_q     <= wr_q ? '0 : served;
          if (remain == '0) begin
            state_q <= LSP_FIN;
          end
        end
        LSP_FIN: begin
          done_q        <= 1'b1;
          done_passes_q <= passes_q;
          state_q       <= LSP_IDLE;
        end
        default: state_q <= LSP_IDLE;
      endcase
    end
  end

  assign done_valid  = done_q;
  assign done_passes = done_passes_q;

  lsp_pass_picker #(
    .LANES (LANES),
    .BANKS (BANKS),
    .ROW_W (ROW_W),
    .DATA_W(DATA_W)
  ) picker_i (
    .pending   (pending_q),
    .lane_bank (lane_bank),
    .lane_row  (lane_row),
    .lane_wdata(wdata_q),
    .served    (served),
    .bank_en   (bank_en),
    .bank_row  (bank_row),
    .bank_wdata(bank_wdata)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    lsp_bank_ram #(
      .ROWS  (ROWS),
      .DATA_W(DATA_W)
    ) ram_i (
      .clk  (clk),
      .en   (running && bank_en[b]),
      .we   (wr_q),
      .row  (bank_row[b]),
      .wdata(bank_wdata[b]),
      .rdata(bank_rdata[b])
    );
  end

  lsp_read_gather #(
    .LANES (LANES),
    .BANKS (BANKS),
    .DATA_W(DATA_W)
  ) gather_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .cap       (cap_q),
    .lane_bank (lane_bank),
    .bank_rdata(bank_rdata),
    .lane_rdata(gath_rdata)
  );

endmodule

// File: rtl/lane_scratchpad_chk.sv
module lane_scratchpad_chk #(
  parameter int LANES  = 16,
  parameter int DATA_W = 32,
  parameter int PCNT_W = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [LANES-1:0]        req_mask,
  input logic                    done_valid,
  input logic [PCNT_W-1:0]       done_passes,
  input logic [LANES*DATA_W-1:0] done_rdata
);

  logic [LANES-1:0]  mask_seen_q;
  logic [PCNT_W:0]   busy_cnt_q;
  logic              inactive_clean;

  // Tracks the accepted mask and the number of busy edges since acceptance.
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_seen_q <= '0;
      busy_cnt_q  <= '0;
    end else if (req_valid && req_ready) begin
      mask_seen_q <= req_mask;
      busy_cnt_q  <= '0;
    end else if (!req_ready) begin
      busy_cnt_q  <= busy_cnt_q + 1'b1;
    end
  end

  always_comb begin
    inactive_clean = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (!mask_seen_q[l] && (done_rdata[l*DATA_W +: DATA_W] != '0)) begin
        inactive_clean = 1'b0;
      end
    end
  end

  a_r7_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  a_r7_done_with_ready: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> req_ready);

  a_r3_pass_range: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> ((done_passes >= PCNT_W'(1)) && (done_passes <= PCNT_W'(LANES))));

  a_r8_pass_matches_cycles: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (({1'b0, done_passes} + 1'b1) == busy_cnt_q));

  a_r6_inactive_zero: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> inactive_clean);

endmodule

bind lane_scratchpad lane_scratchpad_chk #(
  .LANES (LANES),
  .DATA_W(DATA_W),
  .PCNT_W(PCNT_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_mask   (req_mask),
  .done_valid (done_valid),
  .done_passes(done_passes),
  .done_rdata (done_rdata)
);

// File: tb/lane_scratchpad_tb_top.sv
module lane_scratchpad_tb_top;

  localparam int L  = 16;
  localparam int AW = 14;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [L-1:0]    req_mask = '0;
  logic [L*AW-1:0] req_addr = '0;
  logic [L*DW-1:0] req_wdata = '0;
  logic            done_valid;
  logic [4:0]      done_passes;
  logic [L*DW-1:0] done_rdata;

  always #5 clk = ~clk;

  lane_scratchpad dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
    .done_valid(done_valid), .done_passes(done_passes), .done_rdata(done_rdata)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0] mem [4096];
  logic [AW-1:0] st_addr [L];
  logic [DW-1:0] st_data [L];

  int              q_pass [$];
  logic [L*DW-1:0] q_rd   [$];
  int              q_acc  [$];
  string           q_tag  [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [L*DW-1:0] act, input logic [L*DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int w);
    return (DW'(w) * 32'h9E3779B1) ^ 32'h13579BDF;
  endfunction

  // Driver: computes the expected result, queues it, then issues the request.
  task automatic send(input bit wr, input logic [L-1:0] m, input string tag);
    int best;
    logic [L*DW-1:0] exp_rd;
    best = 0;
    exp_rd = '0;
    for (int b = 0; b < 16; b++) begin
      int n;
      n = 0;
      for (int l = 0; l < L; l++) begin
        if (m[l] && (st_addr[l][5:2] == 4'(b))) begin
          bit uniq;
          uniq = 1'b1;
          for (int k = 0; k < l; k++)
            if (m[k] && (st_addr[k][13:2] == st_addr[l][13:2])) uniq = 1'b0;
          if (uniq) n++;
        end
      end
      if (n > best) best = n;
    end
    if (best == 0) best = 1;
    if (wr) begin
      for (int l = 0; l < L; l++)
        if (m[l]) mem[st_addr[l][13:2]] = st_data[l];
    end else begin
      for (int l = 0; l < L; l++)
        exp_rd[l*DW +: DW] = m[l] ? mem[st_addr[l][13:2]] : '0;
    end
    q_pass.push_back(best);
    q_rd.push_back(exp_rd);
    q_tag.push_back(tag);

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_mask  = m;
    for (int l = 0; l < L; l++) begin
      req_addr[l*AW +: AW]  = st_addr[l];
      req_wdata[l*DW +: DW] = st_data[l];
    end
    @(posedge clk);
    #1;
    q_acc.push_back(cyc);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R7", "ready low after accept", {511'd0, req_ready}, '0);
  endtask

  // Monitor: pops and compares as results appear.
  initial begin
    forever begin
      @(negedge clk);
      if (done_valid) begin
        if (q_pass.size() == 0) begin
          check(1'b0, "R7", "unexpected done", '0, '0);
        end else begin
          int ep, acc;
          logic [L*DW-1:0] er;
          string tg;
          ep = q_pass.pop_front();
          er = q_rd.pop_front();
          acc = q_acc.pop_front();
          tg = q_tag.pop_front();
          check(int'(done_passes) == ep, tg, "pass count (R3)",
                {507'd0, done_passes}, (L*DW)'(ep));
          check(done_rdata == er, tg, "read data", done_rdata, er);
          check((cyc - acc) == ep + 1, "R8", "done latency",
                (L*DW)'(cyc - acc), (L*DW)'(ep + 1));
          check(req_ready == 1'b1, "R7", "ready with done", {511'd0, req_ready}, 512'd1);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R9", "reset ready", {511'd0, req_ready}, 512'd1);
    check(done_valid == 1'b0, "R9", "reset done", {511'd0, done_valid}, '0);
    check(done_passes == 5'd0, "R9", "reset passes", {507'd0, done_passes}, '0);
    check(done_rdata == '0, "R9", "reset rdata", done_rdata, '0);

    // Fill the whole memory, one row per request (one pass each).
    for (int r = 0; r < 256; r++) begin
      for (int l = 0; l < L; l++) begin
        st_addr[l] = AW'((r * 16 + l) * 4);
        st_data[l] = pat(r * 16 + l);
      end
      send(1'b1, 16'hFFFF, "R1");
    end

    // Consecutive words: all banks distinct, one pass.
    for (int l = 0; l < L; l++) st_addr[l] = AW'((5 * 16 + l) * 4);
    send(1'b0, 16'hFFFF, "R1");

    // Every lane in bank 2, distinct rows: sixteen passes.
    for (int l = 0; l < L; l++) st_addr[l] = AW'(l * 64 + 8);
    send(1'b0, 16'hFFFF, "R3");

    // Broadcast: all lanes read one word.
    for (int l = 0; l < L; l++) st_addr[l] = AW'(100 * 4);
    send(1'b0, 16'hFFFF, "R4");

    // Mixed: even lanes share a word, odd lanes spread across rows of bank 7.
    for (int l = 0; l < L; l++)
      st_addr[l] = (l % 2 == 0) ? AW'(7 * 4) : AW'((7 + 16 * l) * 4);
    send(1'b0, 16'hFFFF, "R3");

    // Low byte bits ignored.
    for (int l = 0; l < L; l++) st_addr[l] = AW'(200 * 4 + (l % 4));
    send(1'b0, 16'hFFFF, "R1");

    // Many writers of one word: highest lane wins.
    for (int l = 0; l < L; l++) begin
      st_addr[l] = AW'(300 * 4);
      st_data[l] = 32'hD000_0000 + DW'(l);
    end
    send(1'b1, 16'hFFFF, "R5");
    send(1'b0, 16'hFFFF, "R5");

    // No active lane.
    send(1'b0, 16'h0000, "R6");

    // Inactive lanes that would conflict.
    for (int l = 0; l < L; l++) st_addr[l] = AW'(l * 64);
    send(1'b0, 16'h0003, "R6");

    // Inactive writers leave memory unchanged.
    for (int l = 0; l < L; l++) begin
      st_addr[l] = AW'((400 + l) * 4);
      st_data[l] = 32'hBAD0_0000 + DW'(l);
    end
    send(1'b1, 16'h00FF, "R10");
    send(1'b0, 16'hFFFF, "R10");

    // Last address of the space.
    for (int l = 0; l < L; l++) begin
      st_addr[l] = AW'(16383 - 4 * l);
      st_data[l] = 32'hC0DE_0000 + DW'(l);
    end
    send(1'b1, 16'hFFFF, "R2");
    send(1'b0, 16'hFFFF, "R2");

    // Random traffic in a small region to force conflicts.
    for (int it = 0; it < 80; it++) begin
      for (int l = 0; l < L; l++) begin
        st_addr[l] = {8'(20 + $urandom % 4), 4'($urandom), 2'($urandom)};
        st_data[l] = $urandom;
      end
      send(1'($urandom), 16'($urandom), "R2");
    end

    while (q_pass.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule